// File: doc/BRIEF.md
# Asynchronous Host Register Port with Service-Acknowledge Hold-Off

This block is the slave side of an asynchronous, strobe-driven host bus. The host frames each transfer with an active-low chip select, an active-low data strobe and a read/write level. The block brings every strobe into the system clock through two-flop synchronisers. It decodes the transfer against a small 8-bit register file and answers with an active-low acknowledge. During reads the block drives a separate read-data bus and raises an output enable.

A second select input, the vector select, starts a service-acknowledge cycle. This cycle is always a read, and it returns the vector register whatever the address. A write to the end-of-service register starts an internal busy period of `HOLD_CYCLES` clocks, which by default is one microsecond at 250 MHz. Any transfer that starts while the block is busy is held: its acknowledge is withheld until the period is over. A host that waits for acknowledge therefore meets the recovery time without extra logic.

Top module: `hostbus_slave`

## Requirements
- R1: A transfer starts only while the data strobe and at least one select (chip select or vector select) are low together. When the block is not busy, acknowledge goes low on the third rising clock edge after the later of the two inputs falls.
- R2: When `rnw` is 1 (read), `rdata` carries the register at `addr` and `rdata_oe` is 1 from the edge where acknowledge goes low.
- R3: When `rnw` is 0 (write), the register at `addr` takes `wdata` on the same edge where acknowledge goes low. A later read returns that value.
- R4: Acknowledge stays low while any of data strobe, chip select or vector select is still low. It goes high on the third rising edge after the last of them rises.
- R5: A transfer framed by vector select returns the vector register, which sits at address `VEC_ADDR` (default 14), for any value of `addr`.
- R6: A write to address `EOS_ADDR` (default 15) starts a busy period. A transfer pending during that period gets its acknowledge exactly `HOLD_CYCLES`+1 rising edges after the edge that acknowledged the end-of-service write.
- R7: `rdata_oe` is 1 only during read and service-acknowledge transfers. It falls on the same edge where acknowledge rises.
- R8: When chip select and vector select are both low, the transfer is a service-acknowledge read even if `rnw` is 0. No register is written.
- R9: After reset, acknowledge is high, `rdata_oe` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| dstb_n | input | 1 | Data strobe, active low, asynchronous |
| rnw | input | 1 | 1 = read, 0 = write |
| vsel_n | input | 1 | Vector (service-acknowledge) select, active low |
| addr | input | ADDR_W | Register address, held stable through the transfer |
| wdata | input | DATA_W | Write data, held stable through the transfer |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | Read data valid / drive enable |
| xack_n | output | 1 | Transfer acknowledge, active low |

## Verification
Two functions can meet in one cycle. The first is the end-of-service hold-off, triggered by a write to `EOS_ADDR`. The second is the start of the next transfer, which may be a plain read or a service-acknowledge read. The bench provokes this by framing the next transfer the moment the end-of-service acknowledge is released, so the strobes reach the synchroniser while the busy period is still counting. It then judges the acknowledge latency against the exact count of `HOLD_CYCLES` plus one edge. A separate case frames chip select and vector select together with `rnw` low. It checks that the transfer returns the vector register and that a read-back shows the addressed register unchanged.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_e;

    localparam int SYNC_W = 4;   // sel, dstb, vsel, rnw

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_n;
        s2_d = s1_q;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b1;
                s2_q[i] <= 1'b1;
            end else begin
                s1_q[i] <= s1_d[i];
                s2_q[i] <= s2_d[i];
            end
        end
    end

    assign sync_o = ~s2_q;
endmodule

// File: rtl/hb_busy_timer.sv
module hb_busy_timer #(
    parameter int HOLD_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOADV = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOADV;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOADV);
    a_r6_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int VEC_ADDR = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] vec_data
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data  = mem_q[addr];
    assign vec_data = mem_q[ADDR_W'(VEC_ADDR)];

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/hb_cycle_fsm.sv
module hb_cycle_fsm
    import hostbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              dstb_s,
    input  logic              vsel_s,
    input  logic              rnw_s,
    input  logic              busy,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              we,
    output logic              ack,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        bus_state_e        st;
        logic              ack;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic qual, any_low;

    always_comb begin
        nxt_d   = cur_q;
        we      = 1'b0;
        qual    = dstb_s && (sel_s || vsel_s);
        any_low = dstb_s || sel_s || vsel_s;
        unique case (cur_q.st)
            ST_IDLE, ST_HOLD: begin
                if (!qual) begin
                    nxt_d.st = ST_IDLE;
                end else if (busy) begin
                    nxt_d.st = ST_HOLD;
                end else begin
                    nxt_d.st  = ST_ACK;
                    nxt_d.ack = 1'b1;
                    if (vsel_s) begin
                        nxt_d.oe    = 1'b1;
                        nxt_d.rdata = vec_rdata;
                    end else if (rnw_s) begin
                        nxt_d.oe    = 1'b1;
                        nxt_d.rdata = reg_rdata;
                    end else begin
                        we = 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (!any_low) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.ack = 1'b0;
                    nxt_d.oe  = 1'b0;
                end
            end
            default: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.ack = 1'b0;
                nxt_d.oe  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.ack   <= 1'b0;
            cur_q.oe    <= 1'b0;
            cur_q.rdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack   = cur_q.ack;
    assign oe    = cur_q.oe;
    assign rdata = cur_q.rdata;

    a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ack && (dstb_s || sel_s || vsel_s)) |=> cur_q.ack);
    a_r7_oe_inside_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.oe |-> cur_q.ack);
    a_r1_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ack) |-> ($past(dstb_s) && ($past(sel_s) || $past(vsel_s))));
    a_r8_no_write_on_vsel: assert property (@(posedge clk) disable iff (!rst_n)
        vsel_s |-> !we);
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hostbus_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int VEC_ADDR    = 14,
    parameter int EOS_ADDR    = 15,
    parameter int HOLD_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              dstb_n,
    input  logic              rnw,
    input  logic              vsel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              xack_n
);
    logic [SYNC_W-1:0] sync_v;
    logic              sel_s, dstb_s, vsel_s, rnw_s;
    logic              busy, we, ack, eos_start;
    logic [DATA_W-1:0] reg_rdata, vec_rdata;

    hb_sync #(.W(SYNC_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_n({~rnw, vsel_n, dstb_n, sel_n}),
        .sync_o (sync_v)
    );

    assign sel_s  = sync_v[0];
    assign dstb_s = sync_v[1];
    assign vsel_s = sync_v[2];
    assign rnw_s  = sync_v[3];

    hb_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .dstb_s   (dstb_s),
        .vsel_s   (vsel_s),
        .rnw_s    (rnw_s),
        .busy     (busy),
        .reg_rdata(reg_rdata),
        .vec_rdata(vec_rdata),
        .we       (we),
        .ack      (ack),
        .oe       (rdata_oe),
        .rdata    (rdata)
    );

    hb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (reg_rdata),
        .vec_data(vec_rdata)
    );

    assign eos_start = we && (addr == ADDR_W'(EOS_ADDR));

    hb_busy_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(eos_start),
        .busy (busy)
    );

    assign xack_n = ~ack;

    a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> !$past(busy));
endmodule

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;
    localparam int AW = 4, DW = 8, VEC = 14, EOS = 15, HOLD = 250;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, dstb_n = 1'b1, rnw = 1'b1, vsel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_oe, xack_n;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    hostbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dstb_n(dstb_n), .rnw(rnw),
        .vsel_n(vsel_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .xack_n(xack_n)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 read, 1 write, 2 vector read, 3 chip select + vector select with rnw low
    task automatic xfer(input int kind, input int a, input int d, input int stagger,
                        output logic [DW-1:0] rd, output logic oe, output int lat,
                        output int rel);
        addr  = AW'(a);
        wdata = DW'(d);
        rnw   = (kind == 0 || kind == 2);
        if (kind == 2) vsel_n = 1'b0;
        else if (kind == 3) begin vsel_n = 1'b0; sel_n = 1'b0; end
        else sel_n = 1'b0;
        for (int i = 0; i < stagger; i++) @(negedge clk);
        dstb_n = 1'b0;
        lat = 0;
        while (xack_n && lat < 2000) begin @(negedge clk); lat++; end
        rd = rdata;
        oe = rdata_oe;
        sel_n = 1'b1; dstb_n = 1'b1; vsel_n = 1'b1;
        rel = 0;
        while (!xack_n && rel < 2000) begin @(negedge clk); rel++; end
        check(rdata_oe == 1'b0, "R7 oe low after release", rdata_oe, 0);
    endtask

    initial begin
        logic [DW-1:0] rd;
        logic oe;
        int lat, rel;
        repeat (3) @(negedge clk);
        check(xack_n == 1'b1 && rdata_oe == 1'b0, "R9 reset outputs", xack_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        xfer(0, 3, 0, 0, rd, oe, lat, rel);
        check(rd == 0, "R9 register zero after reset", rd, 0);
        check(lat == 3, "R1 read latency", lat, 3);
        check(rel == 3, "R4 release latency", rel, 3);

        // R3 sweep of writes (end-of-service address left for later)
        for (int a = 0; a < (1 << AW); a++) begin
            if (a == EOS) continue;
            xfer(1, a, pat(a), 0, rd, oe, lat, rel);
            check(lat == 3 && oe == 1'b0, "R3 write ack / R7 no oe on write", lat, 3);
        end
        // R2 read-back sweep
        for (int a = 0; a < (1 << AW); a++) begin
            if (a == EOS) continue;
            xfer(0, a, 0, 0, rd, oe, lat, rel);
            check(rd == pat(a) && oe == 1'b1, "R2 R3 read back", rd, pat(a));
        end
        // R5 vector read at every address
        for (int a = 0; a < (1 << AW); a++) begin
            xfer(2, a, 0, 0, rd, oe, lat, rel);
            check(rd == pat(VEC) && oe == 1'b1, "R5 vector read", rd, pat(VEC));
        end
        // R1 latency measured from the later strobe
        xfer(0, 5, 0, 6, rd, oe, lat, rel);
        check(lat == 3 && rd == pat(5), "R1 staggered start", lat, 3);

        // R8 both selects with rnw low: vector returned, register untouched
        xfer(3, 7, 8'hEE, 0, rd, oe, lat, rel);
        check(rd == pat(VEC) && oe == 1'b1, "R8 both selects read vector", rd, pat(VEC));
        xfer(0, 7, 0, 0, rd, oe, lat, rel);
        check(rd == pat(7), "R8 no write on both selects", rd, pat(7));

        // R1 data strobe alone: no start, and no write
        addr = 4'd2; wdata = 8'h99; rnw = 1'b0; dstb_n = 1'b0;
        repeat (8) @(negedge clk);
        check(xack_n == 1'b1, "R1 strobe alone no ack", xack_n, 1);
        dstb_n = 1'b1; @(negedge clk);
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        check(xack_n == 1'b1, "R1 select alone no ack", xack_n, 1);
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
        xfer(0, 2, 0, 0, rd, oe, lat, rel);
        check(rd == pat(2), "R1 ignored strobe left register", rd, pat(2));

        // R4 ack held while select still low
        addr = 4'd4; rnw = 1'b1; sel_n = 1'b0; dstb_n = 1'b0;
        while (xack_n) @(negedge clk);
        dstb_n = 1'b1;
        repeat (6) @(negedge clk);
        check(xack_n == 1'b0 && rdata_oe == 1'b1, "R4 ack held by select", xack_n, 0);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);
        check(xack_n == 1'b1 && rdata_oe == 1'b0, "R4 R7 release after select", xack_n, 1);

        // R6 end-of-service hold-off followed at once by a read
        xfer(1, EOS, 8'h3C, 0, rd, oe, lat, rel);
        xfer(0, 1, 0, 0, rd, oe, lat, rel);
        check(lat == HOLD - 2, "R6 read held off", lat, HOLD - 2);
        check(rd == pat(1), "R6 held read data", rd, pat(1));
        // R6 with a vector read colliding with the busy period
        xfer(1, EOS, 8'h3C, 0, rd, oe, lat, rel);
        xfer(2, 0, 0, 0, rd, oe, lat, rel);
        check(lat == HOLD - 2 && rd == pat(VEC), "R6 R5 vector read held off", lat, HOLD - 2);
        // R6 held write lands
        xfer(1, EOS, 8'h3C, 0, rd, oe, lat, rel);
        xfer(1, 6, 8'hA5, 0, rd, oe, lat, rel);
        check(lat == HOLD - 2, "R6 write held off", lat, HOLD - 2);
        xfer(0, 6, 0, 0, rd, oe, lat, rel);
        check(rd == 8'hA5 && lat == 3, "R6 R3 held write value", rd, 8'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule